// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is the data-register chain that a test access port uses to observe and control a device's pins. It is a row of cells, each tied to one pin. Each cell is one of three kinds: an input cell that only observes, an output cell that drives an open-drain pin, or a bidirectional cell. The TAP controller sits outside the block and supplies the capture, shift and update strobes, the test-mode select and the serial data line. The block does not include the TAP state machine or any pin placement.

A capture strobe copies a value for every cell into its shift stage in parallel. The shift strobe then moves the chain one place toward the serial output on each rising test clock. An update strobe on the falling edge copies the shift stages into per-cell hold latches. Output and bidirectional pins are open-drain. A hold latch value of 0 pulls the pin low. A value of 1 releases the pin, and an external pull-up brings it weakly high. In a bidirectional cell that one bit serves as both the data and the enable, and the cell is its own control cell. With the test mode off, the pins follow the core's own open-drain requests. The core always sees the resolved pin levels.

The shift engine decodes the strobes into three named operations. OP_HOLD is chosen when no strobe is active. OP_CAPTURE is chosen when the capture strobe is high, whatever the shift strobe does. OP_SHIFT is chosen when only the shift strobe is high. Each rising edge applies the current operation, so any operation can follow any other.

Top module: `bsr_chain`

## Requirements
- R1: The chain has NUM_CELLS cells (default 164). Cell 0 drives `tdo` and cell NUM_CELLS-1 takes `tdi`.
- R2: On a rising `tck` with `capture_dr` high, every input and bidirectional cell loads its `pin_in` level into its shift stage.
- R3: On a rising `tck` with `shift_dr` high and `capture_dr` low, each stage takes the value of the next higher cell and the top cell takes `tdi`. `tdo` always shows stage 0.
- R4: When `capture_dr` and `shift_dr` are both high, capture wins. With both low, the stages hold their values.
- R5: On a falling `tck` with `update_dr` high, each output and bidirectional cell copies its shift stage into its hold latch. Without `update_dr` the latch keeps its value.
- R6: While `trst_n` is low, asynchronously, every hold latch is preset to the safe value 1 and every shift stage is cleared to 0.
- R7: With `extest` = 1, an output or bidirectional cell sets `pin_pull_low` exactly when its hold latch is 0. A latch of 1 releases the pin, so it reads weak high.
- R8: With `extest` = 0, an output or bidirectional cell sets `pin_pull_low` exactly when `core_out[i]` is 0, and the hold latch has no effect.
- R9: Input cells never set `pin_pull_low`. `core_in` equals `pin_in` for every cell in both modes.
- R10: An output-only cell captures its own drive: 0 while it pulls low and 1 while it releases, even if something outside pulls its pin low. A bidirectional cell captures the resolved pin, which includes its own low.
- R11: Cell i is an input cell when i mod KIND_PERIOD equals IN_SLOT, and an output cell when it equals OUT_SLOT. All other cells are bidirectional. The defaults are 4, 0 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| capture_dr | input | 1 | Parallel capture strobe |
| shift_dr | input | 1 | Serial shift strobe |
| update_dr | input | 1 | Latch update strobe, acted on at the falling edge |
| extest | input | 1 | 1 = pins driven from hold latches, 0 = pins follow the core |
| tdi | input | 1 | Serial data in, enters cell NUM_CELLS-1 |
| tdo | output | 1 | Serial data out, taken from cell 0 |
| core_out | input | NUM_CELLS | Core drive request per pin, 0 = pull low |
| core_in | output | NUM_CELLS | Resolved pin levels passed to the core |
| pin_in | input | NUM_CELLS | Resolved level on each pin |
| pin_pull_low | output | NUM_CELLS | 1 = open-drain driver pulls the pin low |

## Verification
The assertions check on every cycle that a shift moves cell 1's old value onto `tdo`, that a capture lands the earlier pin level in input and bidirectional stages, and that hold latches either load their stage at an update edge or stay unchanged. Only the bench scenarios can show the rest. These are the pin-drive choice under each mode setting against a pull-up model, the order in which captured values leave the chain, and capture winning over a simultaneous shift. They also cover output cells ignoring outside pulls during capture, and the asynchronous preset during a transfer.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        CELL_INPUT  = 2'd0,
        CELL_OUTPUT = 2'd1,
        CELL_BIDIR  = 2'd2
    } cell_kind_e;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2
    } dr_op_e;

    // Kind of cell at a chain position, from the repeating slot pattern.
    function automatic cell_kind_e kind_at(int idx, int period, int in_slot, int out_slot);
        int slot;
        slot = idx % period;
        if (slot == in_slot)
            return CELL_INPUT;
        else if (slot == out_slot)
            return CELL_OUTPUT;
        else
            return CELL_BIDIR;
    endfunction

endpackage

// File: rtl/bsr_op_decode.sv
module bsr_op_decode
    import bsr_pkg::*;
(
    input  logic   capture_dr,
    input  logic   shift_dr,
    output dr_op_e op
);

    // Capture takes precedence over shift (R4).
    always_comb begin
        unique case ({capture_dr, shift_dr})
            2'b00:   op = OP_HOLD;
            2'b01:   op = OP_SHIFT;
            2'b10:   op = OP_CAPTURE;
            2'b11:   op = OP_CAPTURE;
            default: op = OP_HOLD;
        endcase
    end

endmodule

// File: rtl/bsr_cell.sv
module bsr_cell
    import bsr_pkg::*;
#(
    parameter cell_kind_e KIND = CELL_BIDIR
) (
    input  logic   tck,
    input  logic   trst_n,
    input  dr_op_e op,
    input  logic   update_dr,
    input  logic   extest,
    input  logic   ser_in,
    input  logic   pin_in,
    input  logic   core_out,
    output logic   stage_q,
    output logic   hold_q,
    output logic   pull_low
);

    logic cap_val;

    // Shift stage: capture, shift or hold on the rising edge.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            stage_q <= 1'b0;
        end else begin
            unique case (op)
                OP_CAPTURE: stage_q <= cap_val;
                OP_SHIFT:   stage_q <= ser_in;
                OP_HOLD:    stage_q <= stage_q;
                default:    stage_q <= stage_q;
            endcase
        end
    end

    if (KIND == CELL_INPUT) begin : g_input
        logic unused_ctl;
        assign unused_ctl = ^{core_out, update_dr, extest};
        assign cap_val    = pin_in;
        assign hold_q     = 1'b1;
        assign pull_low   = 1'b0;
    end else begin : g_driver
        // Update latch on the falling edge; preset to the safe value 1.
        always_ff @(negedge tck or negedge trst_n) begin
            if (!trst_n)
                hold_q <= 1'b1;
            else if (update_dr)
                hold_q <= stage_q;
        end

        assign pull_low = extest ? ~hold_q : ~core_out;

        if (KIND == CELL_OUTPUT) begin : g_out_cap
            logic unused_pin;
            assign unused_pin = pin_in;
            assign cap_val    = ~pull_low;
        end else begin : g_bidir_cap
            assign cap_val = pin_in;
        end

        a_r5_update_loads: assert property (@(negedge tck) disable iff (!trst_n)
            update_dr |=> (hold_q == $past(stage_q)));

        a_r5_latch_holds: assert property (@(negedge tck) disable iff (!trst_n)
            !update_dr |=> $stable(hold_q));
    end

    if (KIND != CELL_OUTPUT) begin : g_cap_check
        a_r2_capture_pin: assert property (@(posedge tck) disable iff (!trst_n)
            (op == OP_CAPTURE) |=> (stage_q == $past(pin_in)));
    end

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
    import bsr_pkg::*;
#(
    parameter int NUM_CELLS   = 164,
    parameter int KIND_PERIOD = 4,
    parameter int IN_SLOT     = 0,
    parameter int OUT_SLOT    = 2
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic                 capture_dr,
    input  logic                 shift_dr,
    input  logic                 update_dr,
    input  logic                 extest,
    input  logic                 tdi,
    output logic                 tdo,
    input  logic [NUM_CELLS-1:0] core_out,
    output logic [NUM_CELLS-1:0] core_in,
    input  logic [NUM_CELLS-1:0] pin_in,
    output logic [NUM_CELLS-1:0] pin_pull_low
);

    localparam int LAST = NUM_CELLS - 1;

    dr_op_e               op;
    logic [NUM_CELLS-1:0] stage_q;
    logic [NUM_CELLS-1:0] hold_q;
    logic [NUM_CELLS-1:0] ser_vec;

    bsr_op_decode u_decode (
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .op         (op)
    );

    // Each stage is fed from its higher neighbour; the top one from tdi.
    assign ser_vec = {tdi, stage_q[LAST:1]};

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
        localparam cell_kind_e KIND_I = kind_at(i, KIND_PERIOD, IN_SLOT, OUT_SLOT);
        bsr_cell #(.KIND(KIND_I)) u_cell (
            .tck       (tck),
            .trst_n    (trst_n),
            .op        (op),
            .update_dr (update_dr),
            .extest    (extest),
            .ser_in    (ser_vec[i]),
            .pin_in    (pin_in[i]),
            .core_out  (core_out[i]),
            .stage_q   (stage_q[i]),
            .hold_q    (hold_q[i]),
            .pull_low  (pin_pull_low[i])
        );
    end

    logic unused_hold;
    assign unused_hold = ^hold_q;

    assign tdo     = stage_q[0];
    assign core_in = pin_in;

    a_r3_tdo_follows_shift: assert property (@(posedge tck) disable iff (!trst_n)
        (op == OP_SHIFT) |=> (tdo == $past(stage_q[1])));

endmodule

// File: tb/bsr_chain_bench.sv
`timescale 1ns/1ps
module bsr_chain_bench;

    localparam int N = 164;

    logic         tck = 1'b0;
    logic         trst_n = 1'b1;
    logic         cap = 1'b0, sh = 1'b0, upd = 1'b0, extest = 1'b0, tdi = 1'b0;
    logic [N-1:0] core_out = '1;
    logic [N-1:0] ext_low  = '0;
    logic [N-1:0] core_in, pin_pull_low, pin_in;
    logic         tdo;

    int checks = 0;
    int fails  = 0;
    bit run_cmp = 0;

    always #2.5 tck = ~tck;

    assign pin_in = ~(pin_pull_low | ext_low);

    bsr_chain u_bsr_chain (
        .tck(tck), .trst_n(trst_n), .capture_dr(cap), .shift_dr(sh),
        .update_dr(upd), .extest(extest), .tdi(tdi), .tdo(tdo),
        .core_out(core_out), .core_in(core_in), .pin_in(pin_in),
        .pin_pull_low(pin_pull_low)
    );

    // R11 kind pattern
    function automatic bit is_in(int i);  return (i % 4) == 0; endfunction
    function automatic bit is_out(int i); return (i % 4) == 2; endfunction

    // Behavioural reference model
    logic [N-1:0] m_sr  = '0;
    logic [N-1:0] m_lat = '1;

    function automatic logic m_pull(int i);
        if (is_in(i)) return 1'b0;
        return extest ? ~m_lat[i] : ~core_out[i];
    endfunction

    always @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            m_sr = '0;
        end else if (cap) begin
            for (int i = 0; i < N; i++)
                m_sr[i] = is_out(i) ? ~m_pull(i) : ~(m_pull(i) | ext_low[i]);
        end else if (sh) begin
            m_sr = {tdi, m_sr[N-1:1]};
        end
    end

    always @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            m_lat = '1;
        end else if (upd) begin
            for (int i = 0; i < N; i++)
                if (!is_in(i)) m_lat[i] = m_sr[i];
        end
    end

    task automatic chk_vec(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_bit(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(posedge tck) begin
        logic [N-1:0] ep;
        #4;
        if (run_cmp) begin
            for (int i = 0; i < N; i++) ep[i] = m_pull(i);
            chk_bit("R3 tdo", tdo, m_sr[0]);
            chk_vec(extest ? "R7 pull" : "R8 pull", pin_pull_low, ep);
            chk_vec("R9 core_in", core_in, ~(ep | ext_low));
        end
    end

    task automatic tick();
        @(posedge tck);
        #1;
    endtask

    // Capture-free transfer: out_v[k] is cell k, in_v[k] ends in cell k.
    task automatic shift_io(input logic [N-1:0] in_v, output logic [N-1:0] out_v);
        for (int k = 0; k < N; k++) begin
            out_v[k] = tdo;
            tdi = in_v[k];
            sh  = 1'b1;
            tick();
        end
        sh = 1'b0;
    endtask

    function automatic logic [N-1:0] pat(int seed);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = (((i * seed) + (i >> 2)) % 3) != 0;
        return v;
    endfunction

    function automatic logic [N-1:0] drv_mask();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = !is_in(i);
        return v;
    endfunction

    initial begin
        logic [N-1:0] got, q, e, exp_cap, dm;
        dm = drv_mask();

        // Reset state (R6)
        trst_n = 1'b0;
        run_cmp = 1;
        repeat (3) tick();
        chk_bit("R6 tdo cleared", tdo, 1'b0);
        extest = 1'b1;
        tick();
        chk_vec("R6 latches safe", pin_pull_low, '0);
        extest = 1'b0;
        trst_n = 1'b1;
        tick();

        // Sample mode follows core (R8, R9)
        core_out = pat(5);
        ext_low  = pat(7) & ~pat(5);
        tick();
        chk_vec("R8 core drive", pin_pull_low, ~core_out & dm);
        chk_vec("R9 core_in", core_in, pin_in);

        // Capture and shift out in order (R1, R2, R10, R11)
        cap = 1'b1; tick(); cap = 1'b0;
        shift_io('0, got);
        for (int i = 0; i < N; i++)
            exp_cap[i] = is_out(i) ? core_out[i]
                       : (is_in(i) ? ~ext_low[i] : (core_out[i] & ~ext_low[i]));
        chk_vec("R1 R2 captured order", got, exp_cap);

        // Shift in, update, extest (R3, R5, R7)
        q = pat(11);
        shift_io(q, got);
        chk_vec("R3 zeros shifted through", got, '0);
        upd = 1'b1; tick(); upd = 1'b0; tick();
        extest = 1'b1;
        tick();
        chk_vec("R7 extest drive", pin_pull_low, ~q & dm);

        // Shift without update leaves latches (R5)
        shift_io(~q, got);
        tick();
        chk_vec("R5 latch holds", pin_pull_low, ~q & dm);
        chk_vec("R3 previous content out", got, q);

        // Capture in extest with outside pulls (R10)
        e = pat(13);
        ext_low = e;
        tick();
        cap = 1'b1; tick(); cap = 1'b0;
        shift_io('1, got);
        for (int i = 0; i < N; i++)
            exp_cap[i] = is_out(i) ? q[i]
                       : (is_in(i) ? ~e[i] : (q[i] & ~e[i]));
        chk_vec("R10 capture own drive", got, exp_cap);

        // Capture beats shift; idle holds (R4)
        ext_low = pat(17);
        tick();
        cap = 1'b1; sh = 1'b1; tdi = 1'b1; tick(); cap = 1'b0; sh = 1'b0;
        repeat (3) tick();
        shift_io('0, got);
        for (int i = 0; i < N; i++)
            exp_cap[i] = is_out(i) ? q[i]
                       : (is_in(i) ? ~ext_low[i] : (q[i] & ~ext_low[i]));
        chk_vec("R4 capture wins and holds", got, exp_cap);

        // Async reset in the middle of a shift (R6)
        shift_io(~q, got);
        sh = 1'b1;
        @(posedge tck); #1;
        trst_n = 1'b0;
        #0.5;
        chk_vec("R6 async preset", pin_pull_low, '0);
        chk_bit("R6 async clear", tdo, 1'b0);
        sh = 1'b0;
        tick();
        trst_n = 1'b1;
        tick(); tick();

        run_cmp = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge tck);
        fails++;
        checks++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule